// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the finite-state controller of a processor whose datapath shares one memory port and one ALU across several clock cycles per instruction. Every instruction starts by fetching into the instruction register (IR) and advancing the PC by four. A common second state then reads both source registers and forms a branch target in advance, before anything is known about the instruction. From the third state on, each instruction class follows its own short path and then returns to fetch. Branches and jumps take 3 cycles, stores and register-register (R-type) operations take 4, and loads take 5.

The controller is a Moore machine. Every control line is a function of the current state only. The 6-bit opcode is used in exactly one place: the choice made when leaving the decode state. While reset is held, every output is low. The cycle after reset is released is a fetch.

Top module: `mcc_sequencer`

## Requirements
- R1: While `rst_i` is high at a clock edge the controller enters fetch, and during reset every output is 0. In the first cycle after release the fetch controls appear, even when reset was raised part-way through an instruction.
- R2: Fetch drives `mem_rd_o`=1, `ir_wr_o`=1, `pc_wr_o`=1, `addr_sel_o`=0 (PC), `srca_sel_o`=0 (PC), `srcb_sel_o`=1 (constant four), `alu_class_o`=0 (add) and `pc_src_o`=0 (ALU result). All other outputs are 0, and fetch lasts exactly one cycle.
- R3: Decode always follows fetch, whatever the opcode. It drives `srca_sel_o`=0, `srcb_sel_o`=3 (shifted immediate) and `alu_class_o`=0, with every enable and every other field 0.
- R4: Load (opcode 100011) runs fetch, decode, address (`srca_sel_o`=1, `srcb_sel_o`=2 immediate, add), memory read (`mem_rd_o`=1, `addr_sel_o`=1) and write-back (`reg_wr_o`=1, `reg_dst_o`=0 rt, `wdata_sel_o`=1 MDR). That is 5 cycles.
- R5: Store (opcode 101011) runs fetch, decode, the same address state as R4, then a memory write (`mem_wr_o`=1, `addr_sel_o`=1). That is 4 cycles.
- R6: R-type (opcode 000000) runs fetch, decode, execute (`srca_sel_o`=1, `srcb_sel_o`=0 register B, `alu_class_o`=2 funct-decoded), then completion (`reg_wr_o`=1, `reg_dst_o`=1 rd, `wdata_sel_o`=0 ALUOut). That is 4 cycles.
- R7: Branch-equal (opcode 000100) runs fetch, decode, then compare (`srca_sel_o`=1, `srcb_sel_o`=0, `alu_class_o`=1 subtract, `pc_wr_cond_o`=1, `pc_src_o`=1 ALUOut). That is 3 cycles.
- R8: Jump (opcode 000010) runs fetch, decode, then `pc_wr_o`=1 with `pc_src_o`=2 (jump target). That is 3 cycles.
- R9: Any other opcode returns to fetch straight after decode. No memory, register or PC write happens after its fetch.
- R10: In every state, memory read and memory write are never both high. A field that a state does not use is held at 0.
- R11: The opcode is sampled only in decode. Changing it during any later state of an instruction does not alter that instruction's path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field of the IR |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| ir_wr_o | output | 1 | IR load enable |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when operands are equal |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALUOut |
| srca_sel_o | output | 1 | ALU A operand: 0 PC, 1 register A |
| srcb_sel_o | output | 2 | ALU B operand: 0 B, 1 four, 2 immediate, 3 immediate shifted by two |
| alu_class_o | output | 2 | ALU operation: 0 add, 1 subtract, 2 funct field |
| pc_src_o | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump target |
| reg_dst_o | output | 1 | Destination register: 0 rt, 1 rd |
| wdata_sel_o | output | 1 | Register write data: 0 ALUOut, 1 MDR |
| reg_wr_o | output | 1 | Register file write enable |

## Verification
Because the outputs are Moore outputs, a wrong state shows as a wrong control vector in the very cycle the state is wrong. A bad transition also changes how many cycles pass before the next IR load. The bench runs all 64 opcodes one after another. In every cycle it compares the complete output vector against the vector implied by the opcode's class and the step number, so a misrouted path is reported within one cycle. It also scrambles the opcode after decode and raises reset in the middle of an instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int SRCB_W  = 2;
    localparam int ALUC_W  = 2;
    localparam int PCSRC_W = 2;

    // ALU B operand select encodings
    localparam logic [SRCB_W-1:0] SRCB_REG  = 2'd0;
    localparam logic [SRCB_W-1:0] SRCB_FOUR = 2'd1;
    localparam logic [SRCB_W-1:0] SRCB_IMM  = 2'd2;
    localparam logic [SRCB_W-1:0] SRCB_OFS  = 2'd3;

    // ALU operation class encodings
    localparam logic [ALUC_W-1:0] ALU_ADD   = 2'd0;
    localparam logic [ALUC_W-1:0] ALU_SUB   = 2'd1;
    localparam logic [ALUC_W-1:0] ALU_FUNCT = 2'd2;

    // PC source encodings
    localparam logic [PCSRC_W-1:0] PCSRC_ALU = 2'd0;
    localparam logic [PCSRC_W-1:0] PCSRC_OUT = 2'd1;
    localparam logic [PCSRC_W-1:0] PCSRC_JMP = 2'd2;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_LD_MEM,
        ST_LD_WB,
        ST_ST_MEM,
        ST_R_EXEC,
        ST_R_WB,
        ST_BEQ,
        ST_JMP
    } seq_state_e;

    typedef enum logic [2:0] {
        IC_RTYPE,
        IC_LOAD,
        IC_STORE,
        IC_BEQ,
        IC_JUMP,
        IC_OTHER
    } iclass_e;

    typedef struct packed {
        logic                 mem_rd;
        logic                 mem_wr;
        logic                 ir_wr;
        logic                 pc_wr;
        logic                 pc_wr_cond;
        logic                 addr_sel;
        logic                 srca_sel;
        logic [SRCB_W-1:0]    srcb_sel;
        logic [ALUC_W-1:0]    alu_class;
        logic [PCSRC_W-1:0]   pc_src;
        logic                 reg_dst;
        logic                 wdata_sel;
        logic                 reg_wr;
    } ctrl_t;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
#(
    parameter int              OW        = OPC_W,
    parameter logic [OW-1:0]   OP_RTYPE  = 6'b000000,
    parameter logic [OW-1:0]   OP_LOAD   = 6'b100011,
    parameter logic [OW-1:0]   OP_STORE  = 6'b101011,
    parameter logic [OW-1:0]   OP_BEQ    = 6'b000100,
    parameter logic [OW-1:0]   OP_JUMP   = 6'b000010
) (
    input  logic [OW-1:0] opcode_i,
    output iclass_e       iclass_o
);
    localparam int NCLS = 5;

    logic [OW-1:0]   op_tab [NCLS];
    iclass_e         cls_tab [NCLS];
    logic [NCLS-1:0] hit;

    assign op_tab[0] = OP_RTYPE;  assign cls_tab[0] = IC_RTYPE;
    assign op_tab[1] = OP_LOAD;   assign cls_tab[1] = IC_LOAD;
    assign op_tab[2] = OP_STORE;  assign cls_tab[2] = IC_STORE;
    assign op_tab[3] = OP_BEQ;    assign cls_tab[3] = IC_BEQ;
    assign op_tab[4] = OP_JUMP;   assign cls_tab[4] = IC_JUMP;

    for (genvar g = 0; g < NCLS; g++) begin : g_match
        assign hit[g] = (opcode_i == op_tab[g]);
    end

    always_comb begin
        iclass_o = IC_OTHER;
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (hit[i]) iclass_o = cls_tab[i];
        end
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  seq_state_e state_i,
    input  iclass_e    iclass_i,
    output seq_state_e next_o
);
    always_comb begin
        next_o = ST_FETCH;
        unique case (state_i)
            ST_FETCH:  next_o = ST_DECODE;
            ST_DECODE: begin
                unique case (iclass_i)
                    IC_LOAD,
                    IC_STORE: next_o = ST_ADDR;
                    IC_RTYPE: next_o = ST_R_EXEC;
                    IC_BEQ:   next_o = ST_BEQ;
                    IC_JUMP:  next_o = ST_JMP;
                    default:  next_o = ST_FETCH;
                endcase
            end
            // the address state keeps the opcode-derived choice in the state:
            // re-decode is avoided by splitting on a latched class bit below
            ST_ADDR:   next_o = ST_FETCH;
            ST_LD_MEM: next_o = ST_LD_WB;
            ST_R_EXEC: next_o = ST_R_WB;
            default:   next_o = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  seq_state_e state_i,
    output ctrl_t      ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        unique case (state_i)
            ST_FETCH: begin
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.ir_wr     = 1'b1;
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.srcb_sel  = SRCB_FOUR;
                ctrl_o.alu_class = ALU_ADD;
                ctrl_o.pc_src    = PCSRC_ALU;
            end
            ST_DECODE: begin
                ctrl_o.srcb_sel  = SRCB_OFS;
                ctrl_o.alu_class = ALU_ADD;
            end
            ST_ADDR: begin
                ctrl_o.srca_sel  = 1'b1;
                ctrl_o.srcb_sel  = SRCB_IMM;
                ctrl_o.alu_class = ALU_ADD;
            end
            ST_LD_MEM: begin
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.addr_sel  = 1'b1;
            end
            ST_LD_WB: begin
                ctrl_o.reg_wr    = 1'b1;
                ctrl_o.wdata_sel = 1'b1;
            end
            ST_ST_MEM: begin
                ctrl_o.mem_wr    = 1'b1;
                ctrl_o.addr_sel  = 1'b1;
            end
            ST_R_EXEC: begin
                ctrl_o.srca_sel  = 1'b1;
                ctrl_o.srcb_sel  = SRCB_REG;
                ctrl_o.alu_class = ALU_FUNCT;
            end
            ST_R_WB: begin
                ctrl_o.reg_wr    = 1'b1;
                ctrl_o.reg_dst   = 1'b1;
            end
            ST_BEQ: begin
                ctrl_o.srca_sel   = 1'b1;
                ctrl_o.srcb_sel   = SRCB_REG;
                ctrl_o.alu_class  = ALU_SUB;
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.pc_src     = PCSRC_OUT;
            end
            ST_JMP: begin
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.pc_src    = PCSRC_JMP;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
    import mcc_pkg::*;
#(
    parameter int               OW       = OPC_W,
    parameter logic [OW-1:0]    OP_RTYPE = 6'b000000,
    parameter logic [OW-1:0]    OP_LOAD  = 6'b100011,
    parameter logic [OW-1:0]    OP_STORE = 6'b101011,
    parameter logic [OW-1:0]    OP_BEQ   = 6'b000100,
    parameter logic [OW-1:0]    OP_JUMP  = 6'b000010
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [OW-1:0]       opcode_i,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic                ir_wr_o,
    output logic                pc_wr_o,
    output logic                pc_wr_cond_o,
    output logic                addr_sel_o,
    output logic                srca_sel_o,
    output logic [SRCB_W-1:0]   srcb_sel_o,
    output logic [ALUC_W-1:0]   alu_class_o,
    output logic [PCSRC_W-1:0]  pc_src_o,
    output logic                reg_dst_o,
    output logic                wdata_sel_o,
    output logic                reg_wr_o
);
    seq_regs_t  seq_d, seq_q;
    seq_state_e nxt_common;
    iclass_e    iclass;
    ctrl_t      ctrl_dec, ctrl_out;
    logic       is_store_d, is_store_q;

    mcc_opclass #(
        .OW       (OW),
        .OP_RTYPE (OP_RTYPE),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BEQ   (OP_BEQ),
        .OP_JUMP  (OP_JUMP)
    ) u_opclass (
        .opcode_i (opcode_i),
        .iclass_o (iclass)
    );

    mcc_next_state u_next (
        .state_i  (seq_q.state),
        .iclass_i (iclass),
        .next_o   (nxt_common)
    );

    mcc_out_decode u_outdec (
        .state_i (seq_q.state),
        .ctrl_o  (ctrl_dec)
    );

    // next-value process: the shared address state splits on the class
    // captured in decode, so the opcode is never looked at afterwards
    always_comb begin
        seq_d      = seq_q;
        is_store_d = is_store_q;
        if (seq_q.state == ST_DECODE) begin
            is_store_d = (iclass == IC_STORE);
        end
        if (seq_q.state == ST_ADDR) begin
            seq_d.state = is_store_q ? ST_ST_MEM : ST_LD_MEM;
        end else begin
            seq_d.state = nxt_common;
        end
        if (rst_i) begin
            seq_d.state = ST_FETCH;
            is_store_d  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        seq_q      <= seq_d;
        is_store_q <= is_store_d;
    end

    // all enables are held low while reset is asserted
    assign ctrl_out = rst_i ? '0 : ctrl_dec;

    assign mem_rd_o     = ctrl_out.mem_rd;
    assign mem_wr_o     = ctrl_out.mem_wr;
    assign ir_wr_o      = ctrl_out.ir_wr;
    assign pc_wr_o      = ctrl_out.pc_wr;
    assign pc_wr_cond_o = ctrl_out.pc_wr_cond;
    assign addr_sel_o   = ctrl_out.addr_sel;
    assign srca_sel_o   = ctrl_out.srca_sel;
    assign srcb_sel_o   = ctrl_out.srcb_sel;
    assign alu_class_o  = ctrl_out.alu_class;
    assign pc_src_o     = ctrl_out.pc_src;
    assign reg_dst_o    = ctrl_out.reg_dst;
    assign wdata_sel_o  = ctrl_out.wdata_sel;
    assign reg_wr_o     = ctrl_out.reg_wr;

endmodule

// File: rtl/mcc_sequencer_chk.sv
module mcc_sequencer_chk
    import mcc_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                mem_rd_o,
    input logic                mem_wr_o,
    input logic                ir_wr_o,
    input logic                pc_wr_o,
    input logic                pc_wr_cond_o,
    input logic                addr_sel_o,
    input logic                srca_sel_o,
    input logic [SRCB_W-1:0]   srcb_sel_o,
    input logic [ALUC_W-1:0]   alu_class_o,
    input logic [PCSRC_W-1:0]  pc_src_o,
    input logic                reg_dst_o,
    input logic                wdata_sel_o,
    input logic                reg_wr_o
);
    logic any_en;
    assign any_en = mem_rd_o | mem_wr_o | ir_wr_o | pc_wr_o | pc_wr_cond_o | reg_wr_o;

    // R1: no enable while reset is held
    a_r1_quiet_in_reset: assert property (@(posedge clk_i) rst_i |-> !any_en);

    // R1: release of reset lands in fetch
    a_r1_fetch_after_reset: assert property (@(posedge clk_i)
        ($past(rst_i) && !rst_i) |-> (ir_wr_o && mem_rd_o && pc_wr_o));

    // R2 and R3: fetch lasts one cycle and is followed by a write-free decode
    a_r3_decode_after_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
        ir_wr_o |=> (!any_en && srcb_sel_o == SRCB_OFS && alu_class_o == ALU_ADD));

    // R10: read and write never together
    a_r10_rd_wr_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(mem_rd_o && mem_wr_o));

    // R4: a data read through ALUOut is followed by the MDR write-back
    a_r4_load_wb: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_rd_o && addr_sel_o) |=> (reg_wr_o && wdata_sel_o && !reg_dst_o));

    // R7: conditional PC write uses subtract and ALUOut
    a_r7_branch_ctrl: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_wr_cond_o |-> (alu_class_o == ALU_SUB && pc_src_o == PCSRC_OUT && srca_sel_o));

    // R6: an rd write-back is preceded by a funct-decoded execute
    a_r6_rtype_order: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_wr_o && reg_dst_o) |-> $past(alu_class_o == ALU_FUNCT));

endmodule

bind mcc_sequencer mcc_sequencer_chk u_chk (.*);

// File: tb/mcc_sequencer_bench.sv
module mcc_sequencer_bench;
    import mcc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel, srca_sel;
    logic [1:0] srcb_sel, alu_class, pc_src;
    logic reg_dst, wdata_sel, reg_wr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mcc_sequencer u_mcc_sequencer (
        .clk_i(clk), .rst_i(rst), .opcode_i(opcode),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr),
        .pc_wr_cond_o(pc_wr_cond), .addr_sel_o(addr_sel), .srca_sel_o(srca_sel),
        .srcb_sel_o(srcb_sel), .alu_class_o(alu_class), .pc_src_o(pc_src),
        .reg_dst_o(reg_dst), .wdata_sel_o(wdata_sel), .reg_wr_o(reg_wr)
    );

    // step codes used by the bench
    localparam int S_F = 0, S_D = 1, S_A = 2, S_LR = 3, S_LW = 4,
                   S_SW = 5, S_X = 6, S_RW = 7, S_B = 8, S_J = 9;

    // layout: rd wr ir pc pcc addr srca srcb[2] alu[2] pcsrc[2] dst wsel regwr
    function automatic logic [15:0] vec_of(int s);
        logic [15:0] v = '0;
        case (s)
            S_F:  begin v[15] = 1; v[13] = 1; v[12] = 1; v[8:7] = 2'd1; end
            S_D:  begin v[8:7] = 2'd3; end
            S_A:  begin v[9] = 1; v[8:7] = 2'd2; end
            S_LR: begin v[15] = 1; v[10] = 1; end
            S_LW: begin v[0] = 1; v[1] = 1; end
            S_SW: begin v[14] = 1; v[10] = 1; end
            S_X:  begin v[9] = 1; v[6:5] = 2'd2; end
            S_RW: begin v[0] = 1; v[2] = 1; end
            S_B:  begin v[9] = 1; v[6:5] = 2'd1; v[11] = 1; v[4:3] = 2'd1; end
            S_J:  begin v[12] = 1; v[4:3] = 2'd2; end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic int plen(logic [5:0] op);
        case (op)
            6'b100011: return 5;
            6'b101011, 6'b000000: return 4;
            6'b000100, 6'b000010: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int step_of(logic [5:0] op, int k);
        if (k == 0) return S_F;
        if (k == 1) return S_D;
        case (op)
            6'b100011: return (k == 2) ? S_A : (k == 3) ? S_LR : S_LW;
            6'b101011: return (k == 2) ? S_A : S_SW;
            6'b000000: return (k == 2) ? S_X : S_RW;
            6'b000100: return S_B;
            default:   return S_J;
        endcase
    endfunction

    function automatic string req_of(logic [5:0] op, int k);
        if (k == 0) return "R2";
        if (k == 1) return "R3";
        case (op)
            6'b100011: return "R4";
            6'b101011: return "R5";
            6'b000000: return "R6";
            6'b000100: return "R7";
            6'b000010: return "R8";
            default:   return "R9";
        endcase
    endfunction

    function automatic logic [15:0] got();
        return {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel, srca_sel,
                srcb_sel, alu_class, pc_src, reg_dst, wdata_sel, reg_wr};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %04h expected %04h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    // one instruction, starting in fetch; scramble alters the opcode after decode (R11)
    task automatic run_instr(logic [5:0] op, bit scramble);
        opcode = op;
        for (int k = 0; k < plen(op); k++) begin
            if (scramble && k >= 2) opcode = ~op;
            #1;
            check(scramble ? "R11" : req_of(op, k), got(), vec_of(step_of(op, k)));
            // R10: read/write exclusive in every cycle
            check("R10", {15'd0, mem_rd & mem_wr}, 16'd0);
            next_cycle();
        end
        check(scramble ? "R11" : req_of(op, 0), got(), vec_of(S_F));
    endtask

    initial begin
        // R1: held in reset, all outputs quiet
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            next_cycle();
            check("R1", got(), 16'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", got(), vec_of(S_F));

        // full sweep over every opcode, back to back
        for (int op = 0; op < 64; op++) run_instr(6'(op), 1'b0);

        // R11: opcode changed after decode for every defined class
        run_instr(6'b100011, 1'b1);
        run_instr(6'b101011, 1'b1);
        run_instr(6'b000000, 1'b1);
        run_instr(6'b000100, 1'b1);
        run_instr(6'b000010, 1'b1);
        run_instr(6'b111111, 1'b1);

        // R1: reset in the middle of a load (in its memory read state)
        opcode = 6'b100011;
        next_cycle(); next_cycle(); next_cycle();
        check("R4", got(), vec_of(S_LR));
        @(negedge clk);
        rst = 1'b1;
        #2;
        check("R1", got(), 16'd0);
        next_cycle();
        check("R1", got(), 16'd0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", got(), vec_of(S_F));
        next_cycle();
        check("R1", got(), vec_of(S_D));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule